// File: doc/BRIEF.md
# Single-Dword Completer Request Bridge

This block sits behind a simplified transaction-layer receive port and serves memory requests that carry at most one dword. Each accepted memory write becomes exactly one 32-bit write on a memory-mapped master port. Each accepted memory read becomes one 32-bit read on that port, and the returned dword goes back as a completion with data on a transmit port. A read whose byte enables are all zero is a flush. It touches no slave and is answered at once. A request of any other type is refused with a completion that carries a Completer Abort status and no payload.

Only one request is handled at a time. The receive-ready output is high only while the bridge is idle. It drops in the cycle after a request is accepted and rises again in the cycle after the work for that request is done: the master accepted the write, or the transmit side took the completion. The incoming address goes through a window mask and a base offset before it reaches the master port. A parameter selects whether the base is added or merged by OR.

Top module: `sdw_req_bridge`

## Requirements
- R1: `rx_ready` is high exactly when no request is in progress. A request is accepted on a cycle where `rx_valid` and `rx_ready` are both high. From the next cycle on, `rx_ready` stays low while `m_read`, `m_write` or `tx_valid` is high, and at most one of those three is high at a time.
- R2: A write (`rx_type` = 2'b01) drives `m_write` with the translated address, `rx_be` and `rx_wdata`, all held steady while `m_waitreq` is high. `rx_ready` returns in the cycle after the cycle in which `m_write` is high and `m_waitreq` is low. A write produces no completion.
- R3: A read (`rx_type` = 2'b00) with a nonzero `rx_be` drives `m_read` with the translated address and `rx_be`, held until `m_waitreq` is low. The dword on `m_rdata` is captured only in a cycle where `m_rvalid` is high.
- R4: The completion of a read has `tx_status` = 3'b000, `tx_has_data` = 1, the captured data, and the saved `rx_reqid` and `rx_tag`. All of it is held while `tx_valid` is high and `tx_ready` is low. `rx_ready` returns, and `tx_valid` falls, in the cycle after `tx_valid` and `tx_ready` are both high.
- R5: `m_addr` = BASE + {zeros, `rx_addr`[WIN_BITS-1:2], 2'b00}, with defaults BASE = 32'h8000_0000 and WIN_BITS = 16. Address bits at WIN_BITS and above, and bits [1:0], have no effect.
- R6: `tx_bytecnt` is the span from the lowest set bit of `rx_be` to the highest set bit, inclusive, counted in bytes (1 to 4). It is 1 when `rx_be` is 4'b0000.
- R7: `tx_lowaddr`[6:2] equals `rx_addr`[6:2]. `tx_lowaddr`[1:0] is the index of the lowest set bit of `rx_be`, or 0 when `rx_be` is zero.
- R8: A request with `rx_type` 2'b10 or 2'b11 is unsupported. It causes no master access and returns a completion with `tx_status` = 3'b100 and `tx_has_data` = 0.
- R9: A read with `rx_be` = 4'b0000 is a flush. It causes no master access and returns a completion with `tx_status` = 3'b000, `tx_has_data` = 1 and a data value that carries no meaning.
- R10: After reset `rx_ready` is 1 and `m_read`, `m_write` and `tx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Request offered |
| rx_ready | output | 1 | Bridge idle, can take a request |
| rx_type | input | 2 | 00 read, 01 write, 10/11 unsupported |
| rx_addr | input | IN_AW | Request byte address |
| rx_be | input | 4 | First-dword byte enables |
| rx_tag | input | TAG_W | Request tag |
| rx_reqid | input | RID_W | Requester ID |
| rx_wdata | input | DW | Write dword |
| m_addr | output | MAW | Master address, translated |
| m_be | output | 4 | Master byte enables |
| m_read | output | 1 | Master read request |
| m_write | output | 1 | Master write request |
| m_wdata | output | DW | Master write data |
| m_waitreq | input | 1 | Slave stall |
| m_rdata | input | DW | Slave read data |
| m_rvalid | input | 1 | Slave read data valid |
| tx_valid | output | 1 | Completion offered |
| tx_ready | input | 1 | Transmit side takes the completion |
| tx_status | output | 3 | 000 successful, 100 completer abort |
| tx_has_data | output | 1 | Completion carries one dword |
| tx_reqid | output | RID_W | Saved requester ID |
| tx_tag | output | TAG_W | Saved tag |
| tx_bytecnt | output | BC_W | Byte count |
| tx_lowaddr | output | 7 | Lower address |
| tx_data | output | DW | Completion dword |

## Verification
The bench varies slave stalls, read latency and transmit back-pressure, so that each hold rule is tested across several cycles. A bridge that let a field drift under back-pressure, or captured `m_rdata` before `m_rvalid`, would return the wrong dword. Sparse byte-enable patterns and addresses with set bits outside the window expose a wrong byte count, a wrong lower address, or a leaky translation. Flushes and unsupported types are sent between normal traffic. A design that forwarded them to the slave would produce an unexpected master access, and a design that attached data to an abort would show a wrong `tx_has_data`. Back-to-back requests with `rx_valid` held high catch a bridge that raises ready too early or takes a second request while busy.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
   localparam logic [1:0] KIND_RD = 2'b00;
   localparam logic [1:0] KIND_WR = 2'b01;
   localparam logic [2:0] CPL_SC  = 3'b000;
   localparam logic [2:0] CPL_CA  = 3'b100;

   typedef enum logic [2:0] {
      S_IDLE,
      S_WR,
      S_RD,
      S_RWAIT,
      S_CPL
   } bstate_t;
endpackage

// File: rtl/sdw_addr_xlate.sv
module sdw_addr_xlate #(
   parameter int IN_AW     = 32,
   parameter int OUT_AW    = 32,
   parameter int WIN_BITS  = 16,
   parameter logic [OUT_AW-1:0] BASE = '0,
   parameter bit XLATE_ADD = 1'b1
) (
   input  logic [IN_AW-1:0]  in_addr,
   output logic [OUT_AW-1:0] out_addr
);
   logic [OUT_AW-1:0] win_off;
   logic unused_addr;
   assign unused_addr = ^in_addr;

   generate
      if (WIN_BITS < 3 || WIN_BITS > IN_AW || WIN_BITS > OUT_AW) begin : g_bad_cfg
         initial $error("sdw_addr_xlate: WIN_BITS out of range");
      end
      if (WIN_BITS < OUT_AW) begin : g_pad
         assign win_off = {{(OUT_AW-WIN_BITS){1'b0}}, in_addr[WIN_BITS-1:2], 2'b00};
      end else begin : g_full
         assign win_off = {in_addr[OUT_AW-1:2], 2'b00};
      end
      if (XLATE_ADD) begin : g_add
         assign out_addr = BASE + win_off;
      end else begin : g_or
         assign out_addr = BASE | win_off;
      end
   endgenerate
endmodule

// File: rtl/sdw_cpl_fields.sv
module sdw_cpl_fields #(
   parameter int BC_W = 12
) (
   input  logic [3:0]      be,
   input  logic [4:0]      addr_dw,
   output logic [BC_W-1:0] bytecnt,
   output logic [6:0]      lowaddr
);
   logic [2:0] span;
   logic [1:0] first;

   generate
      if (BC_W < 3) begin : g_bad_cfg
         initial $error("sdw_cpl_fields: BC_W must hold the value 4");
      end
   endgenerate

   always_comb begin
      casez (be)
         4'b1??1:                    span = 3'd4;
         4'b01?1, 4'b1?10:           span = 3'd3;
         4'b0011, 4'b0110, 4'b1100:  span = 3'd2;
         default:                    span = 3'd1;
      endcase
      casez (be)
         4'b???1: first = 2'd0;
         4'b??10: first = 2'd1;
         4'b?100: first = 2'd2;
         4'b1000: first = 2'd3;
         default: first = 2'd0;
      endcase
   end

   assign bytecnt = BC_W'(span);
   assign lowaddr = {addr_dw, first};
endmodule

// File: rtl/sdw_ctrl.sv
module sdw_ctrl
   import sdw_pkg::*;
#(
   parameter int MAW   = 32,
   parameter int DW    = 32,
   parameter int TAG_W = 8,
   parameter int RID_W = 16,
   parameter int BC_W  = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   output logic             rx_ready,
   input  logic [1:0]       rx_type,
   input  logic [3:0]       rx_be,
   input  logic [TAG_W-1:0] rx_tag,
   input  logic [RID_W-1:0] rx_reqid,
   input  logic [DW-1:0]    rx_wdata,
   input  logic [MAW-1:0]   xaddr,
   input  logic [BC_W-1:0]  bc_in,
   input  logic [6:0]       lo_in,
   output logic [MAW-1:0]   m_addr,
   output logic [3:0]       m_be,
   output logic             m_read,
   output logic             m_write,
   output logic [DW-1:0]    m_wdata,
   input  logic             m_waitreq,
   input  logic [DW-1:0]    m_rdata,
   input  logic             m_rvalid,
   output logic             tx_valid,
   input  logic             tx_ready,
   output logic [2:0]       tx_status,
   output logic             tx_has_data,
   output logic [RID_W-1:0] tx_reqid,
   output logic [TAG_W-1:0] tx_tag,
   output logic [BC_W-1:0]  tx_bytecnt,
   output logic [6:0]       tx_lowaddr,
   output logic [DW-1:0]    tx_data
);
   bstate_t          state;
   logic [MAW-1:0]   addr_q;
   logic [3:0]       be_q;
   logic [DW-1:0]    data_q;
   logic [TAG_W-1:0] tag_q;
   logic [RID_W-1:0] rid_q;
   logic [BC_W-1:0]  bc_q;
   logic [6:0]       lo_q;
   logic [2:0]       st_q;
   logic             hd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         addr_q <= '0;
         be_q   <= '0;
         data_q <= '0;
         tag_q  <= '0;
         rid_q  <= '0;
         bc_q   <= '0;
         lo_q   <= '0;
         st_q   <= CPL_SC;
         hd_q   <= 1'b0;
      end else begin
         case (state)
            S_IDLE: if (rx_valid) begin
               addr_q <= xaddr;
               be_q   <= rx_be;
               tag_q  <= rx_tag;
               rid_q  <= rx_reqid;
               bc_q   <= bc_in;
               lo_q   <= lo_in;
               data_q <= rx_wdata;
               if (rx_type == KIND_WR) begin
                  state <= S_WR;
               end else if (rx_type == KIND_RD) begin
                  st_q <= CPL_SC;
                  hd_q <= 1'b1;
                  if (rx_be == 4'b0000) begin
                     data_q <= '0;
                     state  <= S_CPL;
                  end else begin
                     state <= S_RD;
                  end
               end else begin
                  st_q   <= CPL_CA;
                  hd_q   <= 1'b0;
                  data_q <= '0;
                  state  <= S_CPL;
               end
            end
            S_WR:    if (!m_waitreq) state <= S_IDLE;
            S_RD:    if (!m_waitreq) state <= S_RWAIT;
            S_RWAIT: if (m_rvalid) begin
               data_q <= m_rdata;
               state  <= S_CPL;
            end
            S_CPL:   if (tx_ready) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign rx_ready    = (state == S_IDLE);
   assign m_write     = (state == S_WR);
   assign m_read      = (state == S_RD);
   assign tx_valid    = (state == S_CPL);
   assign m_addr      = addr_q;
   assign m_be        = be_q;
   assign m_wdata     = data_q;
   assign tx_data     = data_q;
   assign tx_status   = st_q;
   assign tx_has_data = hd_q;
   assign tx_reqid    = rid_q;
   assign tx_tag      = tag_q;
   assign tx_bytecnt  = bc_q;
   assign tx_lowaddr  = lo_q;
endmodule

// File: rtl/sdw_req_bridge.sv
module sdw_req_bridge #(
   parameter int IN_AW     = 32,
   parameter int MAW       = 32,
   parameter int DW        = 32,
   parameter int TAG_W     = 8,
   parameter int RID_W     = 16,
   parameter int BC_W      = 12,
   parameter int WIN_BITS  = 16,
   parameter logic [MAW-1:0] BASE = 32'h8000_0000,
   parameter bit XLATE_ADD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   output logic             rx_ready,
   input  logic [1:0]       rx_type,
   input  logic [IN_AW-1:0] rx_addr,
   input  logic [3:0]       rx_be,
   input  logic [TAG_W-1:0] rx_tag,
   input  logic [RID_W-1:0] rx_reqid,
   input  logic [DW-1:0]    rx_wdata,
   output logic [MAW-1:0]   m_addr,
   output logic [3:0]       m_be,
   output logic             m_read,
   output logic             m_write,
   output logic [DW-1:0]    m_wdata,
   input  logic             m_waitreq,
   input  logic [DW-1:0]    m_rdata,
   input  logic             m_rvalid,
   output logic             tx_valid,
   input  logic             tx_ready,
   output logic [2:0]       tx_status,
   output logic             tx_has_data,
   output logic [RID_W-1:0] tx_reqid,
   output logic [TAG_W-1:0] tx_tag,
   output logic [BC_W-1:0]  tx_bytecnt,
   output logic [6:0]       tx_lowaddr,
   output logic [DW-1:0]    tx_data
);
   localparam int BE_W = DW / 8;

   logic [MAW-1:0]  xaddr;
   logic [BC_W-1:0] bc_w;
   logic [6:0]      lo_w;

   generate
      if (DW != 32 || BE_W != 4) begin : g_bad_width
         initial $error("sdw_req_bridge: data path must be one 32-bit dword");
      end
      if (IN_AW < 7) begin : g_bad_in_aw
         initial $error("sdw_req_bridge: IN_AW must cover bits [6:2]");
      end
   endgenerate

   sdw_addr_xlate #(
      .IN_AW(IN_AW), .OUT_AW(MAW), .WIN_BITS(WIN_BITS),
      .BASE(BASE), .XLATE_ADD(XLATE_ADD)
   ) u_xlate (
      .in_addr (rx_addr),
      .out_addr(xaddr)
   );

   sdw_cpl_fields #(.BC_W(BC_W)) u_fields (
      .be     (rx_be),
      .addr_dw(rx_addr[6:2]),
      .bytecnt(bc_w),
      .lowaddr(lo_w)
   );

   sdw_ctrl #(
      .MAW(MAW), .DW(DW), .TAG_W(TAG_W), .RID_W(RID_W), .BC_W(BC_W)
   ) u_ctrl (
      .clk, .rst_n, .rx_valid, .rx_ready, .rx_type, .rx_be, .rx_tag,
      .rx_reqid, .rx_wdata,
      .xaddr (xaddr),
      .bc_in (bc_w),
      .lo_in (lo_w),
      .m_addr, .m_be, .m_read, .m_write, .m_wdata, .m_waitreq,
      .m_rdata, .m_rvalid, .tx_valid, .tx_ready, .tx_status,
      .tx_has_data, .tx_reqid, .tx_tag, .tx_bytecnt, .tx_lowaddr, .tx_data
   );
endmodule

// File: rtl/sdw_req_bridge_chk.sv
module sdw_req_bridge_chk #(
   parameter int MAW   = 32,
   parameter int DW    = 32,
   parameter int TAG_W = 8,
   parameter int BC_W  = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_valid,
   input logic             rx_ready,
   input logic             m_read,
   input logic             m_write,
   input logic             m_waitreq,
   input logic [MAW-1:0]   m_addr,
   input logic [3:0]       m_be,
   input logic [DW-1:0]    m_wdata,
   input logic             tx_valid,
   input logic             tx_ready,
   input logic [2:0]       tx_status,
   input logic             tx_has_data,
   input logic [DW-1:0]    tx_data,
   input logic [TAG_W-1:0] tx_tag,
   input logic [BC_W-1:0]  tx_bytecnt
);
   p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (m_read || m_write || tx_valid) |-> !rx_ready);

   p_single_activity_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({m_read, m_write, tx_valid}));

   p_accept_drops_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_ready) |=> !rx_ready);

   p_wr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (m_write && m_waitreq) |=> m_write && $stable(m_addr) && $stable(m_wdata) && $stable(m_be));

   p_wr_ready_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (m_write && !m_waitreq) |=> rx_ready && !m_write && !tx_valid);

   p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (m_read && m_waitreq) |=> m_read && $stable(m_addr) && $stable(m_be));

   p_cpl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data) && $stable(tx_tag)
                                  && $stable(tx_status) && $stable(tx_bytecnt));

   p_cpl_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> rx_ready && !tx_valid);

   p_bytecnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (tx_bytecnt >= BC_W'(1)) && (tx_bytecnt <= BC_W'(4)));

   p_abort_no_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_status == 3'b100) |-> !tx_has_data);
endmodule

bind sdw_req_bridge sdw_req_bridge_chk #(
   .MAW(MAW), .DW(DW), .TAG_W(TAG_W), .BC_W(BC_W)
) u_chk (.*);

// File: tb/sdw_req_bridge_test.sv
`timescale 1ns/100ps
module sdw_req_bridge_test;
   localparam logic [31:0] BASE = 32'h8000_0000;
   localparam int          WIN  = 16;

   typedef struct packed {
      logic        wr;
      logic [31:0] addr;
      logic [3:0]  be;
      logic [31:0] wdata;
   } mst_t;

   typedef struct packed {
      logic [2:0]  st;
      logic        hd;
      logic [15:0] rid;
      logic [7:0]  tag;
      logic [11:0] bc;
      logic [6:0]  lo;
      logic [31:0] data;
      logic        cd;
   } cpl_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic        rx_ready;
   logic [1:0]  rx_type = 2'b00;
   logic [31:0] rx_addr = '0;
   logic [3:0]  rx_be = '0;
   logic [7:0]  rx_tag = '0;
   logic [15:0] rx_reqid = '0;
   logic [31:0] rx_wdata = '0;
   logic [31:0] m_addr;
   logic [3:0]  m_be;
   logic        m_read, m_write;
   logic [31:0] m_wdata;
   logic        m_waitreq = 1'b0;
   logic [31:0] m_rdata = 32'hDEAD_BEEF;
   logic        m_rvalid = 1'b0;
   logic        tx_valid;
   logic        tx_ready = 1'b0;
   logic [2:0]  tx_status;
   logic        tx_has_data;
   logic [15:0] tx_reqid;
   logic [7:0]  tx_tag;
   logic [11:0] tx_bytecnt;
   logic [6:0]  tx_lowaddr;
   logic [31:0] tx_data;

   int checks = 0;
   int fails  = 0;
   int cfg_stall = 0, cfg_lat = 1, cfg_txw = 0;
   bit done = 1'b0;

   mst_t  exp_m[$];
   cpl_t  exp_c[$];
   string exp_ctag[$];

   always #2.5 clk = ~clk;

   sdw_req_bridge uut (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] xlate(input logic [31:0] a);
      return BASE + (a & ((32'h1 << WIN) - 1) & 32'hFFFF_FFFC);
   endfunction

   function automatic logic [31:0] slave_val(input logic [31:0] a);
      return a ^ 32'hC3A5_0F1E;
   endfunction

   function automatic logic [11:0] span_of(input logic [3:0] be);
      int f = -1, l = -1;
      for (int i = 0; i < 4; i++) if (be[i]) begin
         if (f < 0) f = i;
         l = i;
      end
      return (f < 0) ? 12'd1 : 12'(l - f + 1);
   endfunction

   function automatic logic [1:0] first_of(input logic [3:0] be);
      for (int i = 0; i < 4; i++) if (be[i]) return 2'(i);
      return 2'd0;
   endfunction

   // Driver: pushes expectations, then offers the request until taken.
   task automatic send(input logic [1:0] kind, input logic [31:0] a,
                       input logic [3:0] be, input logic [7:0] tag,
                       input logic [15:0] rid, input logic [31:0] wd);
      mst_t m;
      cpl_t c;
      bit   taken;
      m.wr = (kind == 2'b01); m.addr = xlate(a); m.be = be; m.wdata = wd;
      c.rid = rid; c.tag = tag; c.bc = span_of(be);
      c.lo = {a[6:2], first_of(be)};
      if (kind == 2'b01) begin
         exp_m.push_back(m);
      end else if (kind == 2'b00 && be != 4'b0000) begin
         exp_m.push_back(m);
         c.st = 3'b000; c.hd = 1'b1; c.data = slave_val(xlate(a)); c.cd = 1'b1;
         exp_c.push_back(c); exp_ctag.push_back("R4");
      end else if (kind == 2'b00) begin
         c.st = 3'b000; c.hd = 1'b1; c.data = '0; c.cd = 1'b0;
         exp_c.push_back(c); exp_ctag.push_back("R9");
      end else begin
         c.st = 3'b100; c.hd = 1'b0; c.data = '0; c.cd = 1'b0;
         exp_c.push_back(c); exp_ctag.push_back("R8");
      end
      @(posedge clk); #1;
      rx_valid = 1'b1; rx_type = kind; rx_addr = a; rx_be = be;
      rx_tag = tag; rx_reqid = rid; rx_wdata = wd;
      taken = 1'b0;
      while (!taken) begin
         @(negedge clk);
         taken = rx_ready;
         @(posedge clk);
      end
      #1 rx_valid = 1'b0;
      @(negedge clk);
      chk(!rx_ready, "R1", "ready after accept", 64'(rx_ready), 64'd0);
   endtask

   // Slave and transmit-side models (drive just after the edge).
   initial begin
      int   stall_left = 0, rd_cnt = 0, tx_left = 0;
      logic acc_rd = 1'b0;
      logic [31:0] acc_a = '0, pend_a = '0;
      forever begin
         @(posedge clk); #1;
         if (acc_rd) begin rd_cnt = cfg_lat; pend_a = acc_a; end
         m_rvalid = 1'b0; m_rdata = 32'hDEAD_BEEF;
         if (rd_cnt > 0) begin
            rd_cnt--;
            if (rd_cnt == 0) begin m_rvalid = 1'b1; m_rdata = slave_val(pend_a); end
         end
         if (m_read || m_write) begin
            if (stall_left > 0) begin m_waitreq = 1'b1; stall_left--; end
            else m_waitreq = 1'b0;
         end else begin
            m_waitreq = 1'b0; stall_left = cfg_stall;
         end
         acc_rd = m_read && !m_waitreq; acc_a = m_addr;
         if (tx_valid) begin
            if (tx_left > 0) begin tx_ready = 1'b0; tx_left--; end
            else tx_ready = 1'b1;
         end else begin
            tx_ready = 1'b0; tx_left = cfg_txw;
         end
      end
   end

   // Monitor: compares observed master accesses and completions.
   initial begin
      bit   wr_seen = 0, cpl_seen = 0, hold = 0;
      cpl_t snap;
      mst_t m;
      cpl_t c;
      string t;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (wr_seen)
               chk(rx_ready && !tx_valid, "R2", "ready after write", 64'(rx_ready), 64'd1);
            if (cpl_seen)
               chk(rx_ready && !tx_valid, "R4", "ready after completion", 64'(rx_ready), 64'd1);
            if (hold)
               chk(tx_valid && tx_data == snap.data && tx_tag == snap.tag && tx_status == snap.st,
                   "R4", "completion hold", 64'(tx_data), 64'(snap.data));
            wr_seen = 0; cpl_seen = 0; hold = 0;
            if (m_read || m_write || tx_valid)
               chk(!rx_ready, "R1", "busy but ready", 64'(rx_ready), 64'd0);
            if ((m_read || m_write) && !m_waitreq) begin
               if (exp_m.size() == 0) begin
                  chk(1'b0, "R8", "unexpected master access", 64'(m_addr), 64'd0);
               end else begin
                  m = exp_m.pop_front();
                  t = m.wr ? "R2" : "R3";
                  chk(m_write == m.wr && m_read == !m.wr, t, "access kind", 64'(m_write), 64'(m.wr));
                  chk(m_addr == m.addr, "R5", "translated address", 64'(m_addr), 64'(m.addr));
                  chk(m_be == m.be, t, "byte enables", 64'(m_be), 64'(m.be));
                  if (m.wr) begin
                     chk(m_wdata == m.wdata, "R2", "write data", 64'(m_wdata), 64'(m.wdata));
                     wr_seen = 1;
                  end
               end
            end
            if (tx_valid && !tx_ready) begin
               hold = 1; snap.data = tx_data; snap.tag = tx_tag; snap.st = tx_status;
            end
            if (tx_valid && tx_ready) begin
               cpl_seen = 1;
               if (exp_c.size() == 0) begin
                  chk(1'b0, "R2", "unexpected completion", 64'(tx_tag), 64'd0);
               end else begin
                  c = exp_c.pop_front();
                  t = exp_ctag.pop_front();
                  chk(tx_status == c.st, t, "status", 64'(tx_status), 64'(c.st));
                  chk(tx_has_data == c.hd, t, "has_data", 64'(tx_has_data), 64'(c.hd));
                  chk(tx_reqid == c.rid && tx_tag == c.tag, "R4", "reqid/tag",
                      64'({tx_reqid, tx_tag}), 64'({c.rid, c.tag}));
                  chk(tx_bytecnt == c.bc, "R6", "byte count", 64'(tx_bytecnt), 64'(c.bc));
                  chk(tx_lowaddr == c.lo, "R7", "lower address", 64'(tx_lowaddr), 64'(c.lo));
                  if (c.cd) chk(tx_data == c.data, "R3", "read data", 64'(tx_data), 64'(c.data));
               end
            end
         end
      end
   end

   task automatic drain();
      int n = 0;
      while ((exp_m.size() != 0 || exp_c.size() != 0 || !rx_ready) && n < 2000) begin
         @(negedge clk); n++;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(rx_ready, "R10", "ready after reset", 64'(rx_ready), 64'd1);
      chk(!m_read && !m_write && !tx_valid, "R10", "idle outputs",
          64'({m_read, m_write, tx_valid}), 64'd0);

      cfg_stall = 0; cfg_lat = 1; cfg_txw = 0;
      send(2'b01, 32'h0000_1234, 4'b1111, 8'h01, 16'h0100, 32'h1111_2222);
      send(2'b00, 32'h0000_1234, 4'b1111, 8'h02, 16'h0100, 32'h0);
      cfg_stall = 3;
      send(2'b01, 32'h0000_0048, 4'b0101, 8'h03, 16'h0200, 32'hA5A5_5A5A);
      cfg_lat = 4; cfg_txw = 3; cfg_stall = 2;
      send(2'b00, 32'h0000_0064, 4'b0110, 8'h04, 16'h0300, 32'h0);
      send(2'b00, 32'hFFFF_F07F, 4'b1000, 8'h05, 16'h0301, 32'h0);
      send(2'b00, 32'h1234_ABCE, 4'b0011, 8'h06, 16'h0302, 32'h0);
      cfg_stall = 0; cfg_lat = 2; cfg_txw = 1;
      send(2'b00, 32'h0000_0070, 4'b1101, 8'h07, 16'h0400, 32'h0);
      send(2'b00, 32'h0000_0030, 4'b1010, 8'h08, 16'h0401, 32'h0);
      send(2'b00, 32'h0000_0020, 4'b0000, 8'h09, 16'h0500, 32'hFFFF_FFFF);
      send(2'b10, 32'h0000_0044, 4'b1111, 8'h0A, 16'h0600, 32'h0);
      cfg_txw = 4;
      send(2'b11, 32'h0000_0004, 4'b0100, 8'h0B, 16'h0601, 32'h0);
      cfg_stall = 1; cfg_txw = 0;
      send(2'b01, 32'h00FF_FFFF, 4'b0010, 8'h0C, 16'h0700, 32'h7777_0000);
      send(2'b00, 32'h0000_FFFC, 4'b1001, 8'h0D, 16'h0701, 32'h0);
      send(2'b00, 32'h0000_0010, 4'b0000, 8'h0E, 16'h0702, 32'h0);
      drain();
      repeat (4) @(negedge clk);
      chk(exp_m.size() == 0, "R2", "master items left", 64'(exp_m.size()), 64'd0);
      chk(exp_c.size() == 0, "R4", "completions left", 64'(exp_c.size()), 64'd0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired R1 act=hung exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule